// File: doc/BRIEF.md
# Clock-Synthesizer Control Register Bank with Two-Wire Slave

This block is the register file of a clock-synthesizer control core, reached over a standard I2C two-wire bus. A fast system clock samples SCL and SDA and finds START and STOP conditions. A byte engine then matches the device address, takes a register index byte, and moves data bytes into or out of the indexed registers. The device address follows an address-select pin. A master can write or read one register, or a burst of consecutive registers, in a single transfer. A read first sets the index with a write phase, then issues a repeated START with the read address.

Eight control registers sit at indexes 0x00 to 0x07. Four of them (0x01, 0x02, 0x03 and 0x05) are double-buffered. A bus write lands in a shadow copy, and the value the rest of the chip sees changes only when the matching command is written to the write-only command register at index 0x08. Identification values and a live lock-status bit can be read at indexes 0x10 to 0x12. The outputs carry the working register values, together with one-cycle load pulses that tell the loop and phase logic to restart.

Top module: `ctl_regbank`

## Requirements
- R1: The slave acknowledges only the byte addresses 0x4C (write) and 0x4D (read) when `addr_sel_i` is 0, and 0x4E/0x4F when it is 1. Any other address byte is not acknowledged, and the rest of that transfer changes nothing.
- R2: In a write transfer the slave acknowledges the address, the index and every data byte (SDA pulled low in the ninth clock). It takes bits MSB first, and it commits each data byte to the register the index points at.
- R3: A read consists of an index write, a repeated START and the read address. The slave then returns register bytes MSB first, one after another, until the master answers a byte with NACK.
- R4: After each data byte, written or read, only bits 3:0 of the index increment. Bits 7:4 never change, so index 0x0F is followed by 0x00 and 0x1F by 0x10.
- R5: After reset the registers 0x00 to 0x07 read 0x41, 0x00, 0xFF, 0x0F, 0x00, 0x03, 0x00 and 0x80, and every output carries these values.
- R6: Bits with no function always read 0: bits 3, 6 and 7 of 0x01, bits 7:4 of 0x03, bit 6 of 0x04 and bits 7:2 of 0x05.
- R7: A write to 0x01, 0x02 or 0x03 changes what is read back at once. `loop_o` and `fbdiv_o` (= {reg 0x03[3:0], reg 0x02}) change only when a byte with bits 7:4 = 0x5 is written to index 0x08. That write also raises `pll_load_o` for one cycle.
- R8: A write to 0x05 changes what is read back at once. `dpa_res_o` (reg 0x05 bits 1:0) changes only when a byte with bits 3:0 = 0xA is written to index 0x08. That write also raises `dpa_load_o` for one cycle.
- R9: Index 0x10 reads 0x17 and index 0x11 reads 0x01. Index 0x12 reads 0 in every bit except bit 1, which follows `lock_i`.
- R10: Writes to 0x08 through 0x0F and to 0x10 and above are acknowledged and store nothing. Reads of 0x08 through 0x0F and of 0x13 and above return 0x00.
- R11: A STOP that arrives before the eighth bit of a data byte ends the transfer, and that partial byte is not committed.
- R12: Registers 0x00, 0x04, 0x06 and 0x07 drive `ctrl_o`, `phase_o`, `oe_o` and `osc_o` directly, so a write shows on the output without any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad (wired level) |
| addr_sel_i | input | 1 | Selects the address bit 1 of the device byte address |
| lock_i | input | 1 | Lock status from the loop, read at index 0x12 bit 1 |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| ctrl_o | output | 8 | Register 0x00 |
| loop_o | output | 8 | Working copy of register 0x01 |
| fbdiv_o | output | 12 | Working feedback divider {0x03[3:0], 0x02} |
| phase_o | output | 8 | Register 0x04 |
| dpa_res_o | output | 2 | Working copy of register 0x05 bits 1:0 |
| oe_o | output | 8 | Register 0x06 |
| osc_o | output | 8 | Register 0x07 |
| pll_load_o | output | 1 | One-cycle pulse when the loop working copies load |
| dpa_load_o | output | 1 | One-cycle pulse when the phase working copy loads |

## Verification
The assertions assume the master moves SDA only while SCL is low, except for START and STOP. They also assume it never issues START or STOP while the slave holds SDA low, and that each SCL phase lasts longer than the synchronizer delay. Under these assumptions an SDA output change can only fall in an SCL low phase, and two command bytes can never arrive on adjacent cycles. The bench master bit-bangs the bus with quarter periods of five system clocks. It changes data only after SCL has been low for a quarter period, and it ends each transfer with a STOP only after it has released SDA at an acknowledge boundary, or in the middle of a byte that it drives itself.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

  localparam int unsigned NUM_CTL  = 8;
  localparam int unsigned CTL_IW   = $clog2(NUM_CTL);
  localparam logic [7:0]  CMD_IDX  = 8'h08;
  localparam logic [7:0]  ID_IDX   = 8'h10;
  localparam logic [7:0]  REV_IDX  = 8'h11;
  localparam logic [7:0]  STAT_IDX = 8'h12;
  localparam logic [3:0]  PLL_CMD  = 4'h5;
  localparam logic [3:0]  DPA_CMD  = 4'hA;
  localparam int unsigned DPA_REG  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_IDX,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } bus_state_t;

  function automatic logic [7:0] ctl_reset(input int unsigned i);
    case (i)
      0:       return 8'h41;
      2:       return 8'hFF;
      3:       return 8'h0F;
      5:       return 8'h03;
      7:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] ctl_mask(input int unsigned i);
    case (i)
      1:       return 8'h37;
      3:       return 8'h0F;
      4:       return 8'hBF;
      5:       return 8'h03;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit ctl_shadowed(input int unsigned i);
    return (i == 1) || (i == 2) || (i == 3) || (i == 5);
  endfunction

endpackage

// File: rtl/ctl_regbank_sync.sv
module ctl_regbank_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_q;
  logic                   sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ctl_regbank_fsm.sv
module ctl_regbank_fsm
  import ctl_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_BASE = 7'h26
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_sel,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_stb,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);

  bus_state_t state;
  bus_state_t nxt;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic [7:0] tx;
  logic       got;
  logic       mack;
  logic [7:0] idx;
  logic [6:0] my_addr;
  logic [7:0] idx_inc;

  assign my_addr = {DEV_BASE[6:1], addr_sel};
  assign idx_inc = {idx[7:4], idx[3:0] + 4'd1};
  assign rd_idx  = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      got     <= 1'b0;
      mack    <= 1'b0;
      idx     <= '0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_IDX, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) got <= 1'b1;
            end else if (scl_fall && got) begin
              got <= 1'b0;
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == my_addr) begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  nxt    <= sh[0] ? ST_RDATA : ST_IDX;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_IDX) begin
                idx    <= sh;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                nxt    <= ST_WDATA;
              end else begin
                wr_stb  <= 1'b1;
                wr_idx  <= idx;
                wr_data <= sh;
                idx     <= idx_inc;
                sda_oe  <= 1'b1;
                state   <= ST_ACK;
                nxt     <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= nxt;
              cnt    <= '0;
              if (nxt == ST_RDATA) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
            end else if (scl_fall) begin
              if (cnt == 3'd0) begin
                sda_oe <= 1'b0;
                idx    <= idx_inc;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                cnt    <= '0;
                state  <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
            state <= ST_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ctl_regbank_regs.sv
module ctl_regbank_regs
  import ctl_regbank_pkg::*;
#(
  parameter logic [7:0] ID_VAL  = 8'h17,
  parameter logic [7:0] REV_VAL = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic [7:0]           wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [7:0]           rd_idx,
  input  logic                 lock_i,
  output logic [7:0]           rd_data,
  output logic [NUM_CTL*8-1:0] live,
  output logic                 pll_load,
  output logic                 dpa_load
);

  logic [NUM_CTL*8-1:0] shadow_flat;
  logic                 cmd_wr;
  logic                 pll_cmd;
  logic                 dpa_cmd;
  logic [1:0]           lock_sync;

  assign cmd_wr  = wr_stb && (wr_idx == CMD_IDX);
  assign pll_cmd = cmd_wr && (wr_data[7:4] == PLL_CMD);
  assign dpa_cmd = cmd_wr && (wr_data[3:0] == DPA_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_load  <= 1'b0;
      dpa_load  <= 1'b0;
      lock_sync <= '0;
    end else begin
      pll_load  <= pll_cmd;
      dpa_load  <= dpa_cmd;
      lock_sync <= {lock_sync[0], lock_i};
    end
  end

  generate
    for (genvar g = 0; g < NUM_CTL; g++) begin : g_reg
      localparam logic [7:0] RV = ctl_reset(g);
      localparam logic [7:0] MK = ctl_mask(g);
      logic [7:0] sh_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          sh_q <= RV;
        end else if (wr_stb && (wr_idx == 8'(g))) begin
          sh_q <= wr_data & MK;
        end
      end
      assign shadow_flat[g*8 +: 8] = sh_q;

      if (ctl_shadowed(g)) begin : g_dbl
        logic [7:0] work_q;
        logic       load;
        assign load = (g == DPA_REG) ? dpa_cmd : pll_cmd;
        always_ff @(posedge clk) begin
          if (rst) begin
            work_q <= RV;
          end else if (load) begin
            work_q <= sh_q;
          end
        end
        assign live[g*8 +: 8] = work_q;
      end else begin : g_direct
        assign live[g*8 +: 8] = sh_q;
      end
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    if (32'(rd_idx) < NUM_CTL) begin
      rd_data = shadow_flat[32'(rd_idx[CTL_IW-1:0])*8 +: 8];
    end else if (rd_idx == ID_IDX) begin
      rd_data = ID_VAL;
    end else if (rd_idx == REV_IDX) begin
      rd_data = REV_VAL;
    end else if (rd_idx == STAT_IDX) begin
      rd_data = {6'b0, lock_sync[1], 1'b0};
    end
  end

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter logic [6:0]  DEV_BASE    = 7'h26,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  ID_VAL      = 8'h17,
  parameter logic [7:0]  REV_VAL     = 8'h01
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        addr_sel_i,
  input  logic        lock_i,
  output logic        sda_oe_o,
  output logic [7:0]  ctrl_o,
  output logic [7:0]  loop_o,
  output logic [11:0] fbdiv_o,
  output logic [7:0]  phase_o,
  output logic [1:0]  dpa_res_o,
  output logic [7:0]  oe_o,
  output logic [7:0]  osc_o,
  output logic        pll_load_o,
  output logic        dpa_load_o
);

  logic                 bus_scl;
  logic                 bus_sda;
  logic                 scl_rise;
  logic                 scl_fall;
  logic                 start_det;
  logic                 stop_det;
  logic [7:0]           rd_idx;
  logic [7:0]           rd_data;
  logic                 wr_stb;
  logic [7:0]           wr_idx;
  logic [7:0]           wr_data;
  logic [NUM_CTL*8-1:0] live;
  logic                 unused_bits;

  ctl_regbank_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (bus_scl),
    .sda_s     (bus_sda),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  ctl_regbank_fsm #(.DEV_BASE(DEV_BASE)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (bus_sda),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_sel  (addr_sel_i),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_stb    (wr_stb),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o)
  );

  ctl_regbank_regs #(.ID_VAL(ID_VAL), .REV_VAL(REV_VAL)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .lock_i   (lock_i),
    .rd_data  (rd_data),
    .live     (live),
    .pll_load (pll_load_o),
    .dpa_load (dpa_load_o)
  );

  assign ctrl_o      = live[0*8 +: 8];
  assign loop_o      = live[1*8 +: 8];
  assign fbdiv_o     = {live[3*8 +: 4], live[2*8 +: 8]};
  assign phase_o     = live[4*8 +: 8];
  assign dpa_res_o   = live[5*8 +: 2];
  assign oe_o        = live[6*8 +: 8];
  assign osc_o       = live[7*8 +: 8];
  assign unused_bits = ^{live[3*8+4 +: 4], live[5*8+2 +: 6]};

endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_scl,
  input logic        sda_oe_o,
  input logic        pll_load_o,
  input logic        dpa_load_o,
  input logic [7:0]  loop_o,
  input logic [11:0] fbdiv_o,
  input logic [1:0]  dpa_res_o
);

  // R7
  loop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_load_o |-> $stable({loop_o, fbdiv_o}));

  // R8
  dpa_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dpa_load_o |-> $stable(dpa_res_o));

  // R7
  pll_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pll_load_o |=> !pll_load_o);

  // R8
  dpa_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dpa_load_o |=> !dpa_load_o);

  // R2
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !bus_scl);

endmodule

bind ctl_regbank ctl_regbank_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_scl    (bus_scl),
  .sda_oe_o   (sda_oe_o),
  .pll_load_o (pll_load_o),
  .dpa_load_o (dpa_load_o),
  .loop_o     (loop_o),
  .fbdiv_o    (fbdiv_o),
  .dpa_res_o  (dpa_res_o)
);

// File: tb/ctl_regbank_tb.sv
module ctl_regbank_tb;

  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        addr_sel = 1'b0;
  logic        lock = 1'b0;
  logic        sda_bus;
  logic        sda_oe;
  logic [7:0]  ctrl_o, loop_o, phase_o, oe_o, osc_o;
  logic [11:0] fbdiv_o;
  logic [1:0]  dpa_res_o;
  logic        pll_load_o, dpa_load_o;

  int n_chk = 0;
  int n_bad = 0;
  int pll_cnt = 0;
  int dpa_cnt = 0;
  bit done = 1'b0;

  logic [7:0] m_sh [8];
  logic [7:0] m_wk [8];
  logic [7:0] wbuf [16];

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  ctl_regbank u_dut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .addr_sel_i (addr_sel),
    .lock_i     (lock),
    .sda_oe_o   (sda_oe),
    .ctrl_o     (ctrl_o),
    .loop_o     (loop_o),
    .fbdiv_o    (fbdiv_o),
    .phase_o    (phase_o),
    .dpa_res_o  (dpa_res_o),
    .oe_o       (oe_o),
    .osc_o      (osc_o),
    .pll_load_o (pll_load_o),
    .dpa_load_o (dpa_load_o)
  );

  always @(posedge clk) begin
    if (!rst && pll_load_o) pll_cnt <= pll_cnt + 1;
    if (!rst && dpa_load_o) dpa_cnt <= dpa_cnt + 1;
  end

  function automatic logic [7:0] b_mask(input int i);
    case (i)
      1: return 8'h37;
      3: return 8'h0F;
      4: return 8'hBF;
      5: return 8'h03;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] b_rst(input int i);
    case (i)
      0: return 8'h41;
      2: return 8'hFF;
      3: return 8'h0F;
      5: return 8'h03;
      7: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] idx);
    if (idx < 8) return m_sh[idx[2:0]];
    if (idx == 8'h10) return 8'h17;
    if (idx == 8'h11) return 8'h01;
    if (idx == 8'h12) return {6'b0, lock, 1'b0};
    return 8'h00;
  endfunction

  function automatic logic [7:0] own_w();
    return {6'b010011, addr_sel, 1'b0};
  endfunction

  function automatic logic [7:0] nib_inc(input logic [7:0] i);
    return {i[7:4], i[3:0] + 4'd1};
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin
      m_sh[i] = b_rst(i);
      m_wk[i] = b_rst(i);
    end
  endtask

  task automatic m_write(input logic [7:0] idx, input logic [7:0] d);
    if (idx < 8) m_sh[idx[2:0]] = d & b_mask(int'(idx));
    else if (idx == 8'h08) begin
      if (d[3:0] == 4'hA) m_wk[5] = m_sh[5];
      if (d[7:4] == 4'h5) begin
        m_wk[1] = m_sh[1];
        m_wk[2] = m_sh[2];
        m_wk[3] = m_sh[3];
      end
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    check(tag, "outputs",
      {ctrl_o, loop_o, fbdiv_o, phase_o, dpa_res_o, oe_o, osc_o},
      {m_sh[0], m_wk[1], m_wk[3][3:0], m_wk[2], m_sh[4], m_wk[5][1:0], m_sh[6], m_sh[7]});
  endtask

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl = 1'b1; tq();
    sda_m = 1'b0; tq();
    scl = 1'b0; tq();
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; tq();
    scl = 1'b1; tq();
    sda_m = 1'b0; tq();
    scl = 1'b0; tq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tq();
    scl = 1'b1; tq();
    sda_m = 1'b1; tq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tq();
    scl = 1'b1; tq(); tq();
    scl = 1'b0; tq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tq();
    scl = 1'b1; tq();
    ack = ~sda_bus; tq();
    scl = 1'b0; tq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tq();
      scl = 1'b1; tq();
      b[i] = sda_bus; tq();
      scl = 1'b0;
    end
    tq();
    sda_m = ~give_ack; tq();
    scl = 1'b1; tq(); tq();
    scl = 1'b0; tq();
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] dev, input logic [7:0] idx,
                          input int n, input string tag);
    logic ack;
    logic [7:0] p;
    bit own;
    own = (dev == own_w());
    i2c_start();
    send_byte(dev, ack);
    check(tag, "address ack", 64'(ack), 64'(own));
    if (ack) begin
      send_byte(idx, ack);
      check("R2", "index ack", 64'(ack), 64'd1);
      p = idx;
      for (int i = 0; i < n; i++) begin
        send_byte(wbuf[i], ack);
        m_write(p, wbuf[i]);
        p = nib_inc(p);
      end
    end
    i2c_stop();
    tq();
  endtask

  task automatic do_read(input logic [7:0] idx, input int n, input string tag);
    logic ack;
    logic [7:0] b, p;
    i2c_start();
    send_byte(own_w(), ack);
    send_byte(idx, ack);
    i2c_rstart();
    send_byte(own_w() | 8'h01, ack);
    check("R3", "read address ack", 64'(ack), 64'd1);
    p = idx;
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i < n - 1);
      check(tag, $sformatf("read idx %0h", p), 64'(b), 64'(exp_rd(p)));
      p = nib_inc(p);
    end
    i2c_stop();
    tq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int pc, dc;
    logic ack;
    void'($urandom(32'd20240611));
    m_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R5: reset values at the outputs and through a burst read
    chk_outs("R5");
    do_read(8'h00, 8, "R5");

    // R6 / R12: all ones everywhere, reserved bits stay 0
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hFF;
    pc = pll_cnt; dc = dpa_cnt;
    do_write(own_w(), 8'h00, 8, "R2");
    do_read(8'h00, 8, "R6");
    chk_outs("R12");
    check("R7", "no pll load without command", 64'(pll_cnt), 64'(pc));

    // R7: loop working copies load on high nibble 0x5
    wbuf[0] = 8'h5F;
    do_write(own_w(), 8'h08, 1, "R7");
    chk_outs("R7");
    check("R7", "pll load pulse count", 64'(pll_cnt), 64'(pc + 1));
    check("R8", "dpa untouched by pll command", 64'(dpa_cnt), 64'(dc));

    // R8: phase resolution copy loads on low nibble 0xA
    wbuf[0] = 8'h01;
    do_write(own_w(), 8'h05, 1, "R8");
    chk_outs("R8");
    wbuf[0] = 8'h3A;
    do_write(own_w(), 8'h08, 1, "R8");
    chk_outs("R8");
    check("R8", "dpa load pulse count", 64'(dpa_cnt), 64'(dc + 1));
    check("R10", "command register reads 0", 64'(exp_rd(8'h08)), 64'h00);

    // R4: write burst wraps 0x0F -> 0x00
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h5C;
    do_write(own_w(), 8'h0E, 3, "R4");
    chk_outs("R4");
    do_read(8'h0F, 2, "R4");

    // R9 / R4: identification and lock status, wrap 0x1F -> 0x10
    do_read(8'h10, 4, "R9");
    lock = 1'b1; tq();
    do_read(8'h12, 1, "R9");
    do_read(8'h1F, 2, "R4");

    // R10: writes to read-only indexes are acked and ignored
    wbuf[0] = 8'hAA; wbuf[1] = 8'h55;
    do_write(own_w(), 8'h10, 2, "R10");
    do_read(8'h10, 3, "R10");
    do_read(8'h09, 1, "R10");

    // R1: foreign address ignored, then select pin moves the address
    wbuf[0] = 8'h00;
    do_write(8'h4E, 8'h00, 1, "R1");
    chk_outs("R1");
    addr_sel = 1'b1;
    do_write(8'h4C, 8'h00, 1, "R1");
    wbuf[0] = 8'h07;
    do_write(8'h4E, 8'h06, 1, "R1");
    chk_outs("R1");
    do_read(8'h06, 1, "R1");
    addr_sel = 1'b0;

    // R11: STOP inside a data byte discards it
    i2c_start();
    send_byte(own_w(), ack);
    send_byte(8'h06, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_stop();
    tq();
    chk_outs("R11");
    do_read(8'h06, 1, "R11");

    // Random transactions mixed over all index ranges
    for (int t = 0; t < 30; t++) begin
      int r, n;
      logic [7:0] idx;
      r = int'($urandom % 20);
      idx = (r < 16) ? 8'(r) : 8'(8'h10 + r - 16);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      if (($urandom % 4) == 0) lock = ~lock;
      do_write(own_w(), idx, n, "R2");
      chk_outs("R7");
      do_read(idx, n, "R3");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule